// File: doc/BRIEF.md
# Byte FIFO pair with threshold and trailing-data interrupts

This block sits between a register interface and a serial engine and holds two byte queues. The transmit queue is filled by register writes and drained by the engine. The receive queue is filled by the engine and drained by register reads. Each queue reports its fill level and its empty and full state in one status word. Each queue also has a trigger level that software programs, so that the processor is called only when a useful amount of data is waiting or when space has freed up.

Seven events are collected into a sticky interrupt status register: transmit almost-empty, receive almost-full, underrun and overrun for each queue, and a trailing-data event. The trailing-data event fires when received bytes have sat unread for a programmed number of idle periods. With it, a receive queue left below its trigger is still drained. Software clears status bits by writing ones to them. A per-bit enable mask selects which status bits drive the single interrupt line.

Top module: `byte_fifo_irq`

## Requirements
- R1: Each queue returns bytes in the order they were accepted, and its level equals the number of bytes accepted and not yet removed. Full is reported at DEPTH entries, where DEPTH is a parameter supporting 16 or 64.
- R2: The status word carries the TX level in bits 6:0, TX full in bit 7, TX empty in bit 8, the RX level in bits 22:16, RX full in bit 23 and RX empty in bit 24. All other bits are zero.
- R3: A push into a full enabled queue is discarded and leaves its level and contents unchanged. It sets overrun, which is status bit 3 for TX and bit 5 for RX.
- R4: A pop from an empty queue presents the byte value 0 and sets underrun, which is status bit 2 for TX and bit 4 for RX.
- R5: Status bit 0 (TX almost-empty) is set on every clock edge at which the TX queue is enabled and its level is at or below the TX trigger level.
- R6: Status bit 1 (RX almost-full) is set on every clock edge at which the RX queue is enabled and its level is at or above the RX trigger level.
- R7: Status bit 6 (trailing) is set on the idle tick that ends the (limit+1)-th idle period, counted with the RX queue non-empty and no RX push or read. It fires once per quiet stretch. Any RX push or read, or an empty RX queue, restarts the count.
- R8: A status write clears exactly the bits written as one and leaves the others unchanged. An event in the same cycle keeps or sets its bit.
- R9: The interrupt line is high exactly when some status bit and the enable bit at the same position are both one.
- R10: A disabled queue is emptied and reports level 0 and empty. Pushes into it are discarded without setting overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_on | input | 1 | Enables the RX queue |
| tx_on | input | 1 | Enables the TX queue |
| rx_trig | input | 7 | RX almost-full trigger level |
| tx_trig | input | 7 | TX almost-empty trigger level |
| trail_limit | input | 4 | Idle periods counted before the trailing event, minus one |
| int_en | input | 7 | Interrupt enable mask, same bit positions as the status register |
| tx_wr | input | 1 | Register-side push into the TX queue |
| tx_wdata | input | DW | Byte pushed into the TX queue |
| tx_pop | input | 1 | Engine-side pop from the TX queue |
| tx_rdata | output | DW | Head of the TX queue, 0 when empty |
| rx_push | input | 1 | Engine-side push into the RX queue |
| rx_wdata | input | DW | Byte pushed into the RX queue |
| rx_rd | input | 1 | Register-side read (pop) of the RX queue |
| rx_rdata | output | DW | Head of the RX queue, 0 when empty |
| idle_tick | input | 1 | One-cycle pulse marking the end of an idle period |
| stat_wr | input | 1 | Write strobe for the status register |
| stat_wdata | input | 7 | Status write data, a one clears that bit |
| int_status | output | 7 | Sticky interrupt status |
| fifo_status | output | 32 | Level, full and empty word for both queues |
| irq | output | 1 | Interrupt line |

## Verification
Each queue is filled to its depth and past it, then drained past empty. These runs separate correct ordering and level counting from the dropped-push and zero-read cases. Two checks bracket the trigger comparisons. The TX trigger is met only near empty, and the RX trigger is crossed by one byte, which separates at-or-above from strictly-above. A run of idle ticks shows the trailing event arriving on the third tick and not on the second. It also shows that the event does not repeat in the same quiet stretch and fires again after a read. Selective status writes and enable masks then show which bits clear and which drive the line. Disabling the receive queue shows it flushing and ignoring pushes without raising overrun.

// File: rtl/bfi_pkg.sv
package bfi_pkg;
  localparam int FLD_W  = 7;
  localparam int NINT   = 7;
  localparam int TCNT_W = 5;

  localparam int IB_TX_AE    = 0;
  localparam int IB_RX_AF    = 1;
  localparam int IB_TX_UNDER = 2;
  localparam int IB_TX_OVER  = 3;
  localparam int IB_RX_UNDER = 4;
  localparam int IB_RX_OVER  = 5;
  localparam int IB_TRAIL    = 6;

  localparam int SB_TX_LVL   = 0;
  localparam int SB_TX_FULL  = 7;
  localparam int SB_TX_EMPTY = 8;
  localparam int SB_RX_LVL   = 16;
  localparam int SB_RX_FULL  = 23;
  localparam int SB_RX_EMPTY = 24;

  // TX needs service once its level has dropped to the trigger
  function automatic logic low_water(input logic [FLD_W-1:0] lvl,
                                     input logic [FLD_W-1:0] trig);
    return lvl <= trig;
  endfunction

  // RX needs service once its level has climbed to the trigger
  function automatic logic high_water(input logic [FLD_W-1:0] lvl,
                                      input logic [FLD_W-1:0] trig);
    return lvl >= trig;
  endfunction

  // the idle period that matches the limit is the one that expires
  function automatic logic trail_due(input logic [TCNT_W-1:0] cnt,
                                     input logic [3:0] lim);
    return cnt == {1'b0, lim};
  endfunction

  function automatic logic [31:0] pack_status(
      input logic [FLD_W-1:0] tx_lvl, input logic tx_full, input logic tx_empty,
      input logic [FLD_W-1:0] rx_lvl, input logic rx_full, input logic rx_empty);
    logic [31:0] w;
    w = '0;
    w[SB_TX_LVL +: FLD_W] = tx_lvl;
    w[SB_TX_FULL]         = tx_full;
    w[SB_TX_EMPTY]        = tx_empty;
    w[SB_RX_LVL +: FLD_W] = rx_lvl;
    w[SB_RX_FULL]         = rx_full;
    w[SB_RX_EMPTY]        = rx_empty;
    return w;
  endfunction
endpackage

// File: rtl/bfi_fifo.sv
module bfi_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic                       push,
  input  logic [DW-1:0]              wdata,
  input  logic                       pop,
  output logic [DW-1:0]              rdata,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       full,
  output logic                       empty,
  output logic                       ovr_ev,
  output logic                       unr_ev
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] count;
  logic          pop_ok, push_ok;

  assign full    = (count == LW'(DEPTH));
  assign empty   = (count == '0);
  assign pop_ok  = pop & ~empty;
  assign push_ok = en & push & (~full | pop_ok);
  assign ovr_ev  = en & push & full & ~pop_ok;
  assign unr_ev  = pop & empty;
  assign level   = count;
  assign rdata   = empty ? '0 : mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (!en) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
      count <= count + LW'(push_ok) - LW'(pop_ok);
    end
  end

  // R1: the level never passes the depth
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LW'(DEPTH));

  // R3: a rejected push leaves the queue full
  a_r3_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    (en && push && full && !pop) |=> (count == LW'(DEPTH)));

  // R4: popping an empty queue without a push keeps it empty
  a_r4_empty_pop_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);
endmodule

// File: rtl/bfi_trail_timer.sv
module bfi_trail_timer
  import bfi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       activity,
  input  logic       empty,
  input  logic [3:0] limit,
  output logic       fire
);
  logic [TCNT_W-1:0] tcnt;
  logic              quiet;

  assign quiet = ~empty & ~activity;
  assign fire  = tick & quiet & trail_due(tcnt, limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          tcnt <= '0;
    else if (!quiet)                     tcnt <= '0;
    else if (tick && tcnt <= {1'b0, limit}) tcnt <= tcnt + 1'b1;
  end

  // R7: one event per quiet stretch
  a_r7_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
endmodule

// File: rtl/bfi_irq_regs.sv
module bfi_irq_regs
  import bfi_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NINT-1:0] ev,
  input  logic            wr,
  input  logic [NINT-1:0] wmask,
  input  logic [NINT-1:0] en,
  output logic [NINT-1:0] status,
  output logic            irq
);
  logic [NINT-1:0] clr;

  assign clr = wr ? wmask : '0;
  assign irq = |(status & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr) | ev;
  end

  // R8: an event always lands in the status
  a_r8_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((status & $past(ev)) == $past(ev)));

  // R8: written ones without a new event are gone
  a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> ((status & $past(wmask) & ~$past(ev)) == '0));
endmodule

// File: rtl/byte_fifo_irq.sv
module byte_fifo_irq
  import bfi_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_on,
  input  logic            tx_on,
  input  logic [6:0]      rx_trig,
  input  logic [6:0]      tx_trig,
  input  logic [3:0]      trail_limit,
  input  logic [6:0]      int_en,
  input  logic            tx_wr,
  input  logic [DW-1:0]   tx_wdata,
  input  logic            tx_pop,
  output logic [DW-1:0]   tx_rdata,
  input  logic            rx_push,
  input  logic [DW-1:0]   rx_wdata,
  input  logic            rx_rd,
  output logic [DW-1:0]   rx_rdata,
  input  logic            idle_tick,
  input  logic            stat_wr,
  input  logic [6:0]      stat_wdata,
  output logic [6:0]      int_status,
  output logic [31:0]     fifo_status,
  output logic            irq
);
  localparam int LW = $clog2(DEPTH) + 1;

  logic [LW-1:0]    tx_level, rx_level;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic             tx_ovr, tx_unr, rx_ovr, rx_unr;
  logic             trail_fire;
  logic [FLD_W-1:0] tx_lvl7, rx_lvl7;
  logic [NINT-1:0]  ev;

  bfi_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(tx_on),
    .push(tx_wr), .wdata(tx_wdata), .pop(tx_pop), .rdata(tx_rdata),
    .level(tx_level), .full(tx_full), .empty(tx_empty),
    .ovr_ev(tx_ovr), .unr_ev(tx_unr));

  bfi_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(rx_on),
    .push(rx_push), .wdata(rx_wdata), .pop(rx_rd), .rdata(rx_rdata),
    .level(rx_level), .full(rx_full), .empty(rx_empty),
    .ovr_ev(rx_ovr), .unr_ev(rx_unr));

  bfi_trail_timer u_trail (
    .clk(clk), .rst_n(rst_n), .tick(idle_tick),
    .activity(rx_push | rx_rd), .empty(rx_empty),
    .limit(trail_limit), .fire(trail_fire));

  assign tx_lvl7 = FLD_W'(tx_level);
  assign rx_lvl7 = FLD_W'(rx_level);

  always_comb begin
    ev              = '0;
    ev[IB_TX_AE]    = tx_on & low_water(tx_lvl7, tx_trig);
    ev[IB_RX_AF]    = rx_on & high_water(rx_lvl7, rx_trig);
    ev[IB_TX_UNDER] = tx_unr;
    ev[IB_TX_OVER]  = tx_ovr;
    ev[IB_RX_UNDER] = rx_unr;
    ev[IB_RX_OVER]  = rx_ovr;
    ev[IB_TRAIL]    = trail_fire;
  end

  bfi_irq_regs u_irq (
    .clk(clk), .rst_n(rst_n), .ev(ev), .wr(stat_wr), .wmask(stat_wdata),
    .en(int_en), .status(int_status), .irq(irq));

  assign fifo_status = pack_status(tx_lvl7, tx_full, tx_empty,
                                   rx_lvl7, rx_full, rx_empty);

  // R10: a disabled RX queue never raises overrun
  a_r10_off_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_on |-> !rx_ovr);
endmodule

// File: tb/byte_fifo_irq_test.sv
module byte_fifo_irq_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 0;
  logic rst_n = 0;
  logic rx_on = 0, tx_on = 0;
  logic [6:0] rx_trig = 0, tx_trig = 0;
  logic [3:0] trail_limit = 0;
  logic [6:0] int_en = 0;
  logic tx_wr = 0, tx_pop = 0, rx_push = 0, rx_rd = 0, idle_tick = 0, stat_wr = 0;
  logic [7:0] tx_wdata = 0, rx_wdata = 0;
  logic [6:0] stat_wdata = 0;
  logic [7:0] tx_rdata, rx_rdata;
  logic [6:0] int_status;
  logic [31:0] fifo_status;
  logic irq;

  int compared = 0, mismatched = 0;
  bit finished = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_fifo_irq #(.DEPTH(DEPTH), .DW(8)) uut (
    .clk(clk), .rst_n(rst_n), .rx_on(rx_on), .tx_on(tx_on),
    .rx_trig(rx_trig), .tx_trig(tx_trig), .trail_limit(trail_limit),
    .int_en(int_en), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
    .tx_rdata(tx_rdata), .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_rd(rx_rd),
    .rx_rdata(rx_rdata), .idle_tick(idle_tick), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .int_status(int_status),
    .fifo_status(fifo_status), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic tx_send(input logic [7:0] b);
    tx_wr = 1; tx_wdata = b;
    if (txq.size() < DEPTH) txq.push_back(b);
    tick(); tx_wr = 0;
  endtask

  task automatic tx_take();
    tx_pop = 1; tick(); tx_pop = 0;
  endtask

  task automatic rx_send(input logic [7:0] b);
    rx_push = 1; rx_wdata = b;
    if (rx_on && rxq.size() < DEPTH) rxq.push_back(b);
    tick(); rx_push = 0;
  endtask

  task automatic rx_take();
    rx_rd = 1; tick(); rx_rd = 0;
  endtask

  task automatic clr(input logic [6:0] m);
    stat_wr = 1; stat_wdata = m; tick(); stat_wr = 0;
  endtask

  task automatic idle_pulse();
    idle_tick = 1; tick(); idle_tick = 0;
  endtask

  // monitor: compare popped heads against the scoreboard queues
  always @(negedge clk) begin
    if (rst_n && tx_pop) begin
      if (txq.size() > 0) chk("R1 tx order", {24'h0, tx_rdata}, {24'h0, txq.pop_front()});
      else                chk("R4 tx empty read", {24'h0, tx_rdata}, 32'h0);
    end
    if (rst_n && rx_rd) begin
      if (rxq.size() > 0) chk("R1 rx order", {24'h0, rx_rdata}, {24'h0, rxq.pop_front()});
      else                chk("R4 rx empty read", {24'h0, rx_rdata}, 32'h0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    chk("R2 reset status word", fifo_status, 32'h0100_0100);
    chk("R9 reset status", {25'h0, int_status}, 32'h0);
    chk("R9 reset irq", {31'h0, irq}, 32'h0);

    tx_on = 1; rx_on = 1; tx_trig = 7'd2; rx_trig = 7'd4; trail_limit = 4'd2;
    tick();
    chk("R5 almost-empty at level 0", {31'h0, int_status[0]}, 32'h1);

    for (int i = 0; i < 5; i++) tx_send(8'h10 + 8'(i));
    chk("R1 tx level 5", {25'h0, fifo_status[6:0]}, 32'd5);
    for (int i = 5; i < DEPTH; i++) tx_send(8'h10 + 8'(i));
    chk("R2 tx full bit", {31'h0, fifo_status[7]}, 32'h1);
    tx_send(8'hEE);
    chk("R3 tx level after drop", {25'h0, fifo_status[6:0]}, 32'd16);
    chk("R3 tx overrun", {31'h0, int_status[3]}, 32'h1);
    clr(7'h7f);
    chk("R8 clear all above trigger", {25'h0, int_status}, 32'h0);

    for (int i = 0; i < DEPTH; i++) tx_take();
    tx_take();
    chk("R4 tx underrun with R5", {25'h0, int_status}, 32'h05);
    clr(7'h04);
    chk("R8 selective clear", {25'h0, int_status}, 32'h01);

    int_en = 7'h04; #1;
    chk("R9 masked irq", {31'h0, irq}, 32'h0);
    int_en = 7'h01; #1;
    chk("R9 enabled irq", {31'h0, irq}, 32'h1);

    for (int i = 0; i < 3; i++) rx_send(8'hA0 + 8'(i));
    chk("R2 rx level 3", {25'h0, fifo_status[22:16]}, 32'd3);
    tick();
    chk("R6 below trigger", {31'h0, int_status[1]}, 32'h0);
    rx_send(8'hA3);
    tick();
    chk("R6 at trigger", {31'h0, int_status[1]}, 32'h1);
    for (int i = 0; i < 4; i++) rx_take();
    rx_take();
    chk("R4 rx underrun", {31'h0, int_status[4]}, 32'h1);

    for (int i = 0; i < DEPTH + 1; i++) rx_send(8'h40 + 8'(i));
    chk("R3 rx overrun", {31'h0, int_status[5]}, 32'h1);
    chk("R2 full word", fifo_status, 32'h0090_0100);

    clr(7'h7f);
    chk("R7 clear", {31'h0, int_status[6]}, 32'h0);
    idle_pulse(); idle_pulse();
    chk("R7 not yet after 2 ticks", {31'h0, int_status[6]}, 32'h0);
    idle_pulse();
    chk("R7 fires on 3rd tick", {31'h0, int_status[6]}, 32'h1);
    clr(7'h40);
    idle_pulse();
    chk("R7 no repeat", {31'h0, int_status[6]}, 32'h0);
    rx_take();
    idle_pulse(); idle_pulse(); idle_pulse();
    chk("R7 refires after read", {31'h0, int_status[6]}, 32'h1);

    rx_on = 0; rxq.delete();
    tick();
    chk("R10 flushed level", {25'h0, fifo_status[22:16]}, 32'd0);
    chk("R10 empty flag", {31'h0, fifo_status[24]}, 32'h1);
    clr(7'h7f);
    rx_send(8'h55);
    tick();
    chk("R10 push ignored", {25'h0, fifo_status[22:16]}, 32'd0);
    chk("R10 no overrun", {31'h0, int_status[5]}, 32'h0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule